// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This core keeps time of day and a running day number. A one-cycle pulse on `tick_i` arrives once per second. Seconds, minutes and hours are held in packed BCD. Days are a flat 15-bit binary count. A byte-wide register port lets a host set and read the time, load alarm compare values and drive a control register. Reads are combinational and writes take effect at the next clock edge.

An alarm compares minute, hour and day, and each of these fields has its own enable. The compare is made once per minute, when the seconds roll over to 00. A match sets a sticky flag, which the host clears by writing a 1 to it. The interrupt output follows the flag, gated by an enable bit. For a fixed number of cycles after each accepted tick, a busy bit warns the host that the time registers are being updated.

Register addresses: 0 seconds, 1 minutes, 2 hours, 3 day low byte, 4 day high byte, 5 alarm minutes, 6 alarm hours, 7 alarm day low byte, 8 alarm day high byte, 9 control. Control bits: bit 0 count enable, bit 1 interrupt enable, bit 2 alarm flag, bit 3 minute compare enable, bit 4 hour compare enable, bit 5 day compare enable, bit 7 busy.

Top module: `rtc_calendar_core`

## Requirements
- R1: An accepted tick advances seconds through BCD 00..59. The step from 59 gives 00 and carries into minutes, which also count BCD 00..59 and carry on 59.
- R2: Hours count BCD 00..23. A carry into hour 23 gives 00 and increments the day counter by one.
- R3: The day counter is 15-bit binary. Its low byte is at address 3 and bits 14:8 are at address 4, where bit 7 reads 0. It wraps from 0x7FFF to 0.
- R4: Ticks are accepted only while control bit 0 is 1. Otherwise they change no register.
- R5: A write to any time register (addresses 0..4) becomes visible on the next cycle. A tick in the same cycle is discarded, so the write wins and no field advances.
- R6: When seconds roll from 59 to 00, the alarm flag (control bit 2) is set if every enabled field equals its alarm register. Bit 3 enables the minute field (address 5), bit 4 the hour field (address 6) and bit 5 the day field (addresses 7/8). A field that is not enabled is not compared. With no field enabled, the flag sets at every minute rollover.
- R7: The alarm flag stays set until control is written with bit 2 = 1. Writing bit 2 = 0 leaves it unchanged.
- R8: `alarm_irq_o` is 1 exactly while the alarm flag and control bit 1 are both 1.
- R9: Control bit 7 (busy) reads 1 for BUSY_LEN cycles (default 4), starting the cycle after an accepted tick. Writes to it are ignored.
- R10: After reset every register reads 0. Unused addresses (10..15) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per second |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
A wrong carry or BCD digit step shows up as an illegal or skipped value on the time registers at the first read after the failing tick. A wrong day carry only appears at the 23:59:59 boundary, which is why the bench drives that boundary and the 0x7FFF wrap directly. A faulty compare or flag shows up one minute rollover later as a missing or spurious flag bit and a matching interrupt level. A faulty busy timer shows up within BUSY_LEN+1 cycles of a tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FW = 7;   // BCD field storage width
  localparam int DW = 15;  // day counter width

  localparam logic [3:0] A_SEC   = 4'd0;
  localparam logic [3:0] A_MIN   = 4'd1;
  localparam logic [3:0] A_HOUR  = 4'd2;
  localparam logic [3:0] A_DAYL  = 4'd3;
  localparam logic [3:0] A_DAYH  = 4'd4;
  localparam logic [3:0] A_AMIN  = 4'd5;
  localparam logic [3:0] A_AHOUR = 4'd6;
  localparam logic [3:0] A_ADAYL = 4'd7;
  localparam logic [3:0] A_ADAYH = 4'd8;
  localparam logic [3:0] A_CTRL  = 4'd9;

  function automatic logic [FW-1:0] field_max(input int idx);
    return (idx == 2) ? 7'h23 : 7'h59;
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int W = 7,
  parameter logic [W-1:0] MAX = 7'h59
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o,
  output logic         at_max_o
);
  logic [W-1:0] val_q, val_inc;

  always_comb begin
    if (val_q == MAX)             val_inc = '0;
    else if (val_q[3:0] == 4'h9)  val_inc = {val_q[W-1:4] + 1'b1, 4'h0};
    else                          val_inc = val_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= val_inc;
  end

  assign val_o    = val_q;
  assign at_max_o = (val_q == MAX);
endmodule

// File: rtl/rtc_day_counter.sv
module rtc_day_counter #(
  parameter int DW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_lo_i,
  input  logic          load_hi_i,
  input  logic [7:0]    wdata_i,
  input  logic          inc_i,
  output logic [DW-1:0] day_o
);
  logic [DW-1:0] day_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        day_q <= '0;
    else if (load_lo_i) day_q[7:0] <= wdata_i;
    else if (load_hi_i) day_q[DW-1:8] <= wdata_i[DW-9:0];
    else if (inc_i)     day_q <= day_q + 1'b1;  // natural wrap
  end

  assign day_o = day_q;
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter int FW = 7,
  parameter int DW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          roll_i,
  input  logic [FW-1:0] min_i,
  input  logic [FW-1:0] hour_i,
  input  logic [DW-1:0] day_i,
  input  logic [FW-1:0] amin_i,
  input  logic [FW-1:0] ahour_i,
  input  logic [DW-1:0] aday_i,
  input  logic [2:0]    cmp_en_i,
  input  logic          clr_i,
  input  logic          irq_en_i,
  output logic          flag_o,
  output logic          irq_o
);
  logic flag_q, match;

  assign match = (!cmp_en_i[0] || min_i  == amin_i)  &&
                 (!cmp_en_i[1] || hour_i == ahour_i) &&
                 (!cmp_en_i[2] || day_i  == aday_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_q <= 1'b0;
    else if (roll_i && match)  flag_q <= 1'b1;  // set beats clear
    else if (clr_i)            flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/rtc_busy_timer.sv
module rtc_busy_timer #(
  parameter int BUSY_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= CW'(BUSY_LEN);
    else if (cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != 0);
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int AW       = 4,
  parameter int BUSY_LEN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  output logic          alarm_irq_o
);
  localparam int NF = 3;

  logic [FW-1:0] fld_q   [NF];
  logic [NF-1:0] fld_max, fld_inc, fld_load;
  logic          min_inc, hour_inc, day_inc;
  logic [DW-1:0] day_q;
  logic          time_wr, step, roll_q;
  logic          cal_en_q, irq_en_q;
  logic [2:0]    cmp_en_q;
  logic [FW-1:0] amin_q, ahour_q;
  logic [DW-1:0] aday_q;
  logic          flag, busy, ctrl_wr, flag_clr;

  function automatic logic wr_at(input logic [3:0] a);
    return reg_we_i && (reg_addr_i == AW'(a));
  endfunction

  assign time_wr  = reg_we_i && (reg_addr_i <= AW'(A_DAYH));
  assign step     = tick_i && cal_en_q && !time_wr;
  assign min_inc  = step & fld_max[0];
  assign hour_inc = min_inc & fld_max[1];
  assign day_inc  = hour_inc & fld_max[2];
  assign fld_inc  = {hour_inc, min_inc, step};
  assign ctrl_wr  = wr_at(A_CTRL);
  assign flag_clr = ctrl_wr && reg_wdata_i[2];

  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign fld_load[i] = wr_at(4'(i));
    rtc_bcd_field #(.W(FW), .MAX(field_max(i))) u_fld (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (fld_load[i]),
      .load_val_i (reg_wdata_i[FW-1:0]),
      .inc_i      (fld_inc[i]),
      .val_o      (fld_q[i]),
      .at_max_o   (fld_max[i])
    );
  end

  rtc_day_counter #(.DW(DW)) u_day (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_lo_i (wr_at(A_DAYL)),
    .load_hi_i (wr_at(A_DAYH)),
    .wdata_i   (reg_wdata_i),
    .inc_i     (day_inc),
    .day_o     (day_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      cmp_en_q <= '0;
      amin_q   <= '0;
      ahour_q  <= '0;
      aday_q   <= '0;
      roll_q   <= 1'b0;
    end else begin
      roll_q <= step && fld_max[0];  // compare one cycle after seconds -> 00
      if (ctrl_wr) begin
        cal_en_q <= reg_wdata_i[0];
        irq_en_q <= reg_wdata_i[1];
        cmp_en_q <= reg_wdata_i[5:3];
      end
      if (wr_at(A_AMIN))  amin_q  <= reg_wdata_i[FW-1:0];
      if (wr_at(A_AHOUR)) ahour_q <= reg_wdata_i[FW-1:0];
      if (wr_at(A_ADAYL)) aday_q[7:0] <= reg_wdata_i;
      if (wr_at(A_ADAYH)) aday_q[DW-1:8] <= reg_wdata_i[DW-9:0];
    end
  end

  rtc_alarm_unit #(.FW(FW), .DW(DW)) u_alarm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .roll_i   (roll_q),
    .min_i    (fld_q[1]),
    .hour_i   (fld_q[2]),
    .day_i    (day_q),
    .amin_i   (amin_q),
    .ahour_i  (ahour_q),
    .aday_i   (aday_q),
    .cmp_en_i (cmp_en_q),
    .clr_i    (flag_clr),
    .irq_en_i (irq_en_q),
    .flag_o   (flag),
    .irq_o    (alarm_irq_o)
  );

  rtc_busy_timer #(.BUSY_LEN(BUSY_LEN)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (step),
    .busy_o  (busy)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(A_SEC):   reg_rdata_o = {1'b0, fld_q[0]};
      AW'(A_MIN):   reg_rdata_o = {1'b0, fld_q[1]};
      AW'(A_HOUR):  reg_rdata_o = {1'b0, fld_q[2]};
      AW'(A_DAYL):  reg_rdata_o = day_q[7:0];
      AW'(A_DAYH):  reg_rdata_o = {1'b0, day_q[DW-1:8]};
      AW'(A_AMIN):  reg_rdata_o = {1'b0, amin_q};
      AW'(A_AHOUR): reg_rdata_o = {1'b0, ahour_q};
      AW'(A_ADAYL): reg_rdata_o = aday_q[7:0];
      AW'(A_ADAYH): reg_rdata_o = {1'b0, aday_q[DW-1:8]};
      AW'(A_CTRL):  reg_rdata_o = {busy, 1'b0, cmp_en_q, flag, irq_en_q, cal_en_q};
      default:      reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        step,
  input logic        reg_we_i,
  input logic [3:0]  reg_addr_i,
  input logic [7:0]  reg_wdata_i,
  input logic [6:0]  sec,
  input logic [6:0]  min,
  input logic [6:0]  hour,
  input logic [14:0] day,
  input logic        cal_en,
  input logic        flag,
  input logic        busy
);
  logic at_eod;
  assign at_eod = step && sec == 7'h59 && min == 7'h59 && hour == 7'h23;

  assert_sec_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && sec == 7'h59) |=> (sec == 7'h00));

  assert_day_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_eod && day != 15'h7FFF) |=> (hour == 7'h00 && day == 15'($past(day) + 15'd1)));

  assert_day_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_eod && day == 15'h7FFF) |=> (day == 15'h0000));

  assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cal_en && !reg_we_i) |=> ($stable(sec) && $stable(day)));

  assert_write_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 4'd0) |=> (sec == $past(reg_wdata_i[6:0])));

  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !(reg_we_i && reg_addr_i == 4'd9 && reg_wdata_i[2])) |=> flag);

  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> busy);
endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .step        (step),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .sec         (fld_q[0]),
  .min         (fld_q[1]),
  .hour        (fld_q[2]),
  .day         (day_q),
  .cal_en      (cal_en_q),
  .flag        (flag),
  .busy        (busy)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
  localparam int BL = 4;

  logic       clk = 0, rst_n = 0, tick = 0, we = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       irq;
  int total = 0, bad = 0;

  // bench model, binary values
  int m_sec = 0, m_min = 0, m_hour = 0, m_day = 0;
  int a_min = 0, a_hour = 0, a_day = 0;
  bit m_en = 0, m_ien = 0, m_flag = 0;
  bit [2:0] m_cmp = 0;

  always #4 clk = ~clk;

  rtc_calendar_core #(.BUSY_LEN(BL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .alarm_irq_o(irq)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] ctrl_byte();
    return {1'b0, 1'b0, m_cmp, m_flag, m_ien, m_en};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic model_step();
    if (!m_en) return;
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hour++;
        if (m_hour == 24) begin m_hour = 0; m_day = (m_day + 1) & 32'h7FFF; end
      end
      if ((!m_cmp[0] || m_min == a_min) && (!m_cmp[1] || m_hour == a_hour) &&
          (!m_cmp[2] || m_day == a_day)) m_flag = 1;
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    model_step();
    repeat (BL + 2) @(negedge clk);
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int d);
    wr(0, bcd(s)); wr(1, bcd(mi)); wr(2, bcd(h));
    wr(3, 8'(d)); wr(4, 8'(d >> 8));
    m_sec = s; m_min = mi; m_hour = h; m_day = d;
  endtask

  task automatic set_alarm(input int mi, input int h, input int d);
    wr(5, bcd(mi)); wr(6, bcd(h)); wr(7, 8'(d)); wr(8, 8'(d >> 8));
    a_min = mi; a_hour = h; a_day = d;
  endtask

  task automatic set_ctrl(input bit en, input bit ien, input bit [2:0] cmp, input bit clr);
    wr(9, {2'b00, cmp, clr, ien, en});
    m_en = en; m_ien = ien; m_cmp = cmp;
    if (clr) m_flag = 0;
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    rd(0, v); check({req, " sec"}, v, bcd(m_sec));
    rd(1, v); check({req, " min"}, v, bcd(m_min));
    rd(2, v); check({req, " hour"}, v, bcd(m_hour));
    rd(3, v); check({req, " day_lo"}, v, 8'(m_day));
    rd(4, v); check({req, " day_hi"}, v, 8'(m_day >> 8));
    rd(9, v); check({req, " ctrl"}, v, ctrl_byte());
    check({req, " irq"}, {7'd0, irq}, {7'd0, m_flag & m_ien});
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset state and unused address
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v); check("R10 reset/unused read", v, 8'h00);
    end

    // R4 ticks ignored while disabled
    set_time(59, 59, 23, 100);
    do_tick();
    check_all("R4 disabled");

    // R9 busy window, R1/R2 carry at end of day
    set_ctrl(1, 0, 3'b000, 1);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; model_step();
    addr = 9; #1; check("R9 busy first", rdata & 8'h80, 8'h80);
    repeat (BL - 1) @(negedge clk);
    #1; check("R9 busy last", rdata & 8'h80, 8'h80);
    @(negedge clk); #1; check("R9 busy ended", rdata & 8'h80, 8'h00);
    check_all("R2 day carry");
    set_ctrl(1, 0, 3'b000, 1);

    // R9 busy bit not writable
    wr(9, 8'h81); m_en = 1; m_ien = 0; m_cmp = 0;
    rd(9, v); check("R9 busy write ignored", v, 8'h01);

    // R3 day wrap and high byte bit 7
    set_time(59, 59, 23, 32'h7FFF);
    do_tick();
    check_all("R3 day wrap");
    wr(4, 8'hFF); m_day = 32'h7F00;
    rd(4, v); check("R3 day_hi bit7", v, 8'h7F);

    // R5 write wins over tick in same cycle
    set_time(10, 20, 5, 7);
    @(negedge clk); tick = 1; we = 1; addr = 0; wdata = 8'h30;
    @(negedge clk); tick = 0; we = 0;
    m_sec = 30;
    rd(1, v); check("R5 min untouched", v, bcd(20));
    rd(0, v); check("R5 sec written", v, bcd(30));
    repeat (BL) @(negedge clk);
    rd(9, v); check("R5 no busy", v & 8'h80, 8'h00);

    // R6/R8 alarm with all fields enabled, R7 sticky and W1C
    set_time(58, 14, 9, 300);
    set_alarm(15, 9, 300);
    set_ctrl(1, 1, 3'b111, 1);
    do_tick(); do_tick();
    check("R6 match flag", {7'd0, m_flag}, 8'd1);
    check_all("R6 R8 alarm match");
    set_ctrl(1, 1, 3'b111, 0);
    rd(9, v); check("R7 write0 keeps flag", v & 8'h04, 8'h04);
    set_ctrl(1, 0, 3'b111, 0);
    check("R8 irq gated", {7'd0, irq}, 8'd0);
    set_ctrl(1, 1, 3'b111, 1);
    check_all("R7 W1C clear");

    // R6 mismatch on day, then day compare disabled
    set_time(59, 14, 9, 301);
    do_tick();
    check_all("R6 day mismatch");
    set_time(59, 14, 9, 301);
    set_ctrl(1, 1, 3'b011, 1);
    do_tick();
    check_all("R6 day disabled");
    set_ctrl(1, 1, 3'b000, 1);
    set_time(59, 40, 2, 5);
    do_tick();
    check_all("R6 no enables");

    // random runs, R1 R2 R6
    for (int it = 0; it < 24; it++) begin
      int s, mi, h, d, n;
      s = 50 + int'($urandom_range(9)); mi = int'($urandom_range(59));
      h = int'($urandom_range(23)); d = int'($urandom_range(32767));
      if (it % 4 == 0) begin mi = 59; h = 23; end
      set_time(s, mi, h, d);
      if ($urandom_range(1) == 1) set_alarm((mi + 1) % 60, h, d);
      else set_alarm(int'($urandom_range(59)), int'($urandom_range(23)), d);
      set_ctrl(1, 1'($urandom_range(1)), 3'($urandom_range(7)), 1);
      n = 1 + int'($urandom_range(15));
      for (int k = 0; k < n; k++) do_tick();
      check_all("R1 R2 R6 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule